// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block sits on the system side of a processor. It walks the processor into its low-power states and brings it back out. A sleep request pulls the active-low stop-clock line low. Once the processor reports that its stop-grant cycle has completed, the block waits out a hold interval and then pulls the active-low sleep line low. A further interval later it gates the bus clock off, which is the deepest state. A wake request reverses the order. The clock comes back first and is given a settling interval. The block then waits a lock latency counted in microsecond reference ticks, releases the sleep line, and releases the stop-clock line last.

Every minimum interval is enforced by one shared down-counter. The counter counts bus-clock cycles, except during the lock wait, where it counts reference ticks. The block also drives an input-freeze flag that tells neighbouring logic to hold the processor's inputs constant (reset is exempt). The flag is raised when the stop-grant completes and is dropped only after the exit hold intervals have run out.

A wake request that arrives while the block is still entering a state is remembered. It is acted on only when that state has reached its stable point, so no minimum interval is ever cut short. All interval lengths are parameters.

Top module: `pwr_state_seq`

## Requirements
- R1: After reset, stpClkN = 1, slpN = 1, busClkEn = 1 and inputFreeze = 0.
- R2: A one-cycle sleepReq in the running state drives stpClkN low on the next cycle. inputFreeze stays low until a stopGrantDone pulse arrives, and it rises on the cycle after that pulse.
- R3: With no wake pending, slpN falls exactly GRANT_TO_SLP (default 100) cycles after the clock edge that samples stopGrantDone.
- R4: With no wake pending, busClkEn falls exactly SLP_TO_STOP (default 10) cycles after slpN falls.
- R5: In the clock-gated state, a one-cycle wakeReq raises busClkEn on the next cycle. slpN then stays low for SETTLE_CYC cycles followed by PLL_TICKS pulses of usTick; the tick that arrives on the entry cycle of the lock wait is not counted. slpN rises only while busClkEn is high.
- R6: After slpN rises, stpClkN stays low for exactly SLP_EXIT_HOLD (default 10) cycles.
- R7: After stpClkN rises, inputFreeze stays high for exactly STP_EXIT_HOLD (default 8) cycles and then falls. It never falls while stpClkN or slpN is low.
- R8: A wakeReq that arrives while slpN is low and busClkEn is still high is held. slpN then rises exactly SLP_TO_STOP cycles after its fall, and busClkEn never drops.
- R9: A wakeReq that arrives after sleepReq but before stopGrantDone is held. stpClkN rises on the cycle after inputFreeze rises, and slpN never falls.
- R10: wakeReq and stopGrantDone in the running state, and wakeReq while leaving the low-power states, have no effect. They change no output and are not remembered for the next entry.
- R11: sleepReq outside the running state has no effect: intervals in progress keep their length, and no new entry starts after the return to the running state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock; the block's own clock is never gated |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | One-cycle request to start entering the low-power states |
| stopGrantDone | input | 1 | One-cycle pulse: the processor's stop-grant cycle has completed |
| wakeReq | input | 1 | One-cycle request to return to the running state |
| usTick | input | 1 | One-cycle pulse once per microsecond |
| stpClkN | output | 1 | Active-low stop-clock request to the processor |
| slpN | output | 1 | Active-low sleep request to the processor |
| busClkEn | output | 1 | Enable for the processor's bus clock |
| inputFreeze | output | 1 | High while the processor's inputs must be held constant |

## Verification
The full descent to the clock-gated state and back is measured edge to edge. This checks each interval for its exact length, so a counter that is off by one, or an interval that has been skipped, shows up as a wrong count. The lock wait runs with a tick period of 7 cycles, which separates counting ticks from counting cycles. Two scenarios place the wake request early: one during the sleep hold and one before the stop-grant completes. These show that a wake is held until the stable point, and that the shallow exit paths skip the states they should skip. Stray requests are then sent in the running, sleep and exit states. Each run afterwards proves that the intervals keep their length and that nothing is carried into the next entry.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_STOPGRANT,
    ST_SLEEP,
    ST_DEEPSLEEP,
    ST_CLKSETTLE,
    ST_PLLLOCK,
    ST_SLEEPEXIT,
    ST_STPEXIT
  } seqState_t;

  typedef enum logic [2:0] {
    LD_GRANT,
    LD_SLPSTOP,
    LD_SETTLE,
    LD_PLL,
    LD_SLPEXIT,
    LD_STPEXIT
  } loadSel_t;

  typedef struct packed {
    logic     load;
    loadSel_t sel;
    logic     tickMode;
  } seqStrobe_t;

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer
  import pwr_seq_pkg::*;
#(
  parameter int GRANT_TO_SLP  = 100,
  parameter int SLP_TO_STOP   = 10,
  parameter int SETTLE_CYC    = 15,
  parameter int PLL_TICKS     = 30,
  parameter int SLP_EXIT_HOLD = 10,
  parameter int STP_EXIT_HOLD = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  input  logic       usTick,
  output logic       expired
);

  localparam int MAX_A   = (GRANT_TO_SLP > SLP_TO_STOP) ? GRANT_TO_SLP : SLP_TO_STOP;
  localparam int MAX_B   = (SETTLE_CYC > PLL_TICKS) ? SETTLE_CYC : PLL_TICKS;
  localparam int MAX_C   = (SLP_EXIT_HOLD > STP_EXIT_HOLD) ? SLP_EXIT_HOLD : STP_EXIT_HOLD;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_ALL = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int CNT_W   = $clog2(MAX_ALL + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;
  logic             stepEn;

  // Cycle intervals load N-1 so the state lasts exactly N cycles;
  // the lock wait loads the full tick count.
  always_comb begin
    case (strb.sel)
      LD_GRANT:   loadVal = CNT_W'(GRANT_TO_SLP - 1);
      LD_SLPSTOP: loadVal = CNT_W'(SLP_TO_STOP - 1);
      LD_SETTLE:  loadVal = CNT_W'(SETTLE_CYC - 1);
      LD_PLL:     loadVal = CNT_W'(PLL_TICKS);
      LD_SLPEXIT: loadVal = CNT_W'(SLP_EXIT_HOLD - 1);
      LD_STPEXIT: loadVal = CNT_W'(STP_EXIT_HOLD - 1);
      default:    loadVal = '0;
    endcase
  end

  assign stepEn = (cnt != '0) && (!strb.tickMode || usTick);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (strb.load) cnt <= loadVal;
    else if (stepEn)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // Counter parks at zero; it never wraps to the top value (interval lengths, R3-style holds rely on this)
  assert_cnt_no_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cnt) == '0 && !$past(strb.load)) |-> cnt == '0);

  // In tick mode the counter only moves on a tick (R5)
  assert_tick_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.tickMode) && !$past(strb.load) && !$past(usTick)) |-> $stable(cnt));

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int SLP_TO_STOP = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic       stopGrantDone,
  input  logic       wakeReq,
  input  logic       expired,
  output seqStrobe_t strb,
  output logic       stpClkN,
  output logic       slpN,
  output logic       busClkEn,
  output logic       inputFreeze
);

  localparam int LOW_W = $clog2(SLP_TO_STOP + 1) + 1;

  seqState_t state, nextState;
  logic      grantSeen;
  logic      wakePend;
  logic      wakeAny;
  logic      wakeClr;
  logic      entryState;

  assign wakeAny    = wakeReq | wakePend;
  assign entryState = (state == ST_STOPGRANT) || (state == ST_SLEEP) || (state == ST_DEEPSLEEP);

  always_comb begin
    nextState     = state;
    strb.load     = 1'b0;
    strb.sel      = LD_GRANT;
    strb.tickMode = (state == ST_PLLLOCK);
    wakeClr       = 1'b0;
    case (state)
      ST_RUN: begin
        if (sleepReq) nextState = ST_STOPGRANT;
      end
      ST_STOPGRANT: begin
        if (!grantSeen) begin
          if (stopGrantDone) begin
            strb.load = 1'b1;
            strb.sel  = LD_GRANT;
          end
        end else if (wakeAny) begin
          nextState = ST_STPEXIT;
          strb.load = 1'b1;
          strb.sel  = LD_STPEXIT;
          wakeClr   = 1'b1;
        end else if (expired) begin
          nextState = ST_SLEEP;
          strb.load = 1'b1;
          strb.sel  = LD_SLPSTOP;
        end
      end
      ST_SLEEP: begin
        if (expired) begin
          if (wakeAny) begin
            nextState = ST_SLEEPEXIT;
            strb.load = 1'b1;
            strb.sel  = LD_SLPEXIT;
            wakeClr   = 1'b1;
          end else begin
            nextState = ST_DEEPSLEEP;
          end
        end
      end
      ST_DEEPSLEEP: begin
        if (wakeAny) begin
          nextState = ST_CLKSETTLE;
          strb.load = 1'b1;
          strb.sel  = LD_SETTLE;
          wakeClr   = 1'b1;
        end
      end
      ST_CLKSETTLE: begin
        if (expired) begin
          nextState = ST_PLLLOCK;
          strb.load = 1'b1;
          strb.sel  = LD_PLL;
        end
      end
      ST_PLLLOCK: begin
        if (expired) begin
          nextState = ST_SLEEPEXIT;
          strb.load = 1'b1;
          strb.sel  = LD_SLPEXIT;
        end
      end
      ST_SLEEPEXIT: begin
        if (expired) begin
          nextState = ST_STPEXIT;
          strb.load = 1'b1;
          strb.sel  = LD_STPEXIT;
        end
      end
      ST_STPEXIT: begin
        if (expired) nextState = ST_RUN;
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_RUN;
      grantSeen <= 1'b0;
      wakePend  <= 1'b0;
    end else begin
      state     <= nextState;
      grantSeen <= (nextState == ST_STOPGRANT) &&
                   (grantSeen || (state == ST_STOPGRANT && stopGrantDone));
      if (wakeClr)                    wakePend <= 1'b0;
      else if (wakeReq && entryState) wakePend <= 1'b1;
    end
  end

  assign stpClkN     = (state == ST_RUN) || (state == ST_STPEXIT);
  assign slpN        = !((state == ST_SLEEP) || (state == ST_DEEPSLEEP) ||
                         (state == ST_CLKSETTLE) || (state == ST_PLLLOCK));
  assign busClkEn    = (state != ST_DEEPSLEEP);
  assign inputFreeze = (state == ST_STOPGRANT) ? grantSeen : (state != ST_RUN);

  // Checker-only count of cycles the sleep line has been low (saturating)
  logic [LOW_W-1:0] slpLowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                slpLowCnt <= '0;
    else if (slpN)            slpLowCnt <= '0;
    else if (~&slpLowCnt)     slpLowCnt <= slpLowCnt + 1'b1;
  end

  assert_slp_fall_after_grant_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(slpN) |-> (inputFreeze && !stpClkN));

  assert_gate_after_slp_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busClkEn) |-> (!slpN && slpLowCnt >= LOW_W'(SLP_TO_STOP)));

  assert_slp_rise_clock_on_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slpN) |-> (busClkEn && $past(busClkEn)));

  assert_stpclk_rise_after_slp_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stpClkN) |-> (slpN && $past(slpN)));

  assert_freeze_drop_last_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inputFreeze) |-> (stpClkN && slpN && busClkEn));

  assert_no_pending_in_run_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> !wakePend);

endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pwr_seq_pkg::*;
#(
  parameter int GRANT_TO_SLP  = 100,
  parameter int SLP_TO_STOP   = 10,
  parameter int SETTLE_CYC    = 15,
  parameter int PLL_TICKS     = 30,
  parameter int SLP_EXIT_HOLD = 10,
  parameter int STP_EXIT_HOLD = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepReq,
  input  logic stopGrantDone,
  input  logic wakeReq,
  input  logic usTick,
  output logic stpClkN,
  output logic slpN,
  output logic busClkEn,
  output logic inputFreeze
);

  seqStrobe_t strb;
  logic       expired;

  pwr_seq_ctrl #(
    .SLP_TO_STOP (SLP_TO_STOP)
  ) uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .sleepReq      (sleepReq),
    .stopGrantDone (stopGrantDone),
    .wakeReq       (wakeReq),
    .expired       (expired),
    .strb          (strb),
    .stpClkN       (stpClkN),
    .slpN          (slpN),
    .busClkEn      (busClkEn),
    .inputFreeze   (inputFreeze)
  );

  pwr_seq_timer #(
    .GRANT_TO_SLP  (GRANT_TO_SLP),
    .SLP_TO_STOP   (SLP_TO_STOP),
    .SETTLE_CYC    (SETTLE_CYC),
    .PLL_TICKS     (PLL_TICKS),
    .SLP_EXIT_HOLD (SLP_EXIT_HOLD),
    .STP_EXIT_HOLD (STP_EXIT_HOLD)
  ) uTimer (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .usTick  (usTick),
    .expired (expired)
  );

endmodule

// File: tb/tb_pwr_state_seq.sv
`timescale 1ns/1ps
module tb_pwr_state_seq;

  localparam int GRANT_TO_SLP  = 100;
  localparam int SLP_TO_STOP   = 10;
  localparam int SETTLE_CYC    = 15;
  localparam int PLL_TICKS     = 4;
  localparam int SLP_EXIT_HOLD = 10;
  localparam int STP_EXIT_HOLD = 8;
  localparam int TICK_PER      = 7;
  localparam int LIMIT         = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 1'b0;
  logic stopGrantDone = 1'b0;
  logic wakeReq = 1'b0;
  logic usTick = 1'b0;
  logic stpClkN, slpN, busClkEn, inputFreeze;

  int checks = 0;
  int fails = 0;
  logic clkDropped = 1'b0;
  logic slpDropped = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  pwr_state_seq #(
    .GRANT_TO_SLP  (GRANT_TO_SLP),
    .SLP_TO_STOP   (SLP_TO_STOP),
    .SETTLE_CYC    (SETTLE_CYC),
    .PLL_TICKS     (PLL_TICKS),
    .SLP_EXIT_HOLD (SLP_EXIT_HOLD),
    .STP_EXIT_HOLD (STP_EXIT_HOLD)
  ) dut (
    .clk (clk), .rstN (rstN), .sleepReq (sleepReq), .stopGrantDone (stopGrantDone),
    .wakeReq (wakeReq), .usTick (usTick), .stpClkN (stpClkN), .slpN (slpN),
    .busClkEn (busClkEn), .inputFreeze (inputFreeze)
  );

  initial begin
    forever begin
      repeat (TICK_PER - 1) @(negedge clk);
      usTick = 1'b1;
      @(negedge clk);
      usTick = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rstN && !busClkEn) clkDropped <= 1'b1;
    if (rstN && !slpN)     slpDropped <= 1'b1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic logic sigOf(input int which);
    case (which)
      0: return stpClkN;
      1: return slpN;
      2: return busClkEn;
      default: return inputFreeze;
    endcase
  endfunction

  // Count negedges, starting at the current one, while the signal keeps its level
  task automatic measure(input int which, input logic lvl, output int n);
    n = 0;
    while (sigOf(which) == lvl && n < LIMIT) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulseSleep();
    sleepReq = 1'b1; @(negedge clk); sleepReq = 1'b0;
  endtask
  task automatic pulseGrant();
    stopGrantDone = 1'b1; @(negedge clk); stopGrantDone = 1'b0;
  endtask
  task automatic pulseWake();
    wakeReq = 1'b1; @(negedge clk); wakeReq = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 stpClkN", stpClkN, 1);
    check("R1 slpN", slpN, 1);
    check("R1 busClkEn", busClkEn, 1);
    check("R1 inputFreeze", inputFreeze, 0);
  endtask

  task automatic testDeepCycle();
    int n;
    pulseSleep();
    check("R2 stpClkN low", stpClkN, 0);
    check("R2 freeze before grant", inputFreeze, 0);
    repeat (3) @(negedge clk);
    check("R2 freeze still low", inputFreeze, 0);
    pulseGrant();
    check("R2 freeze after grant", inputFreeze, 1);
    measure(1, 1'b1, n);
    check("R3 grant to slp", n, GRANT_TO_SLP);
    measure(2, 1'b1, n);
    check("R4 slp to clock stop", n, SLP_TO_STOP);
    repeat (5) @(negedge clk);
    check("R4 clock stays gated", busClkEn, 0);
    pulseWake();
    check("R5 clock back on", busClkEn, 1);
    measure(1, 1'b0, n);
    checkRange("R5 settle plus lock", n, SETTLE_CYC + (PLL_TICKS - 1) * TICK_PER + 2,
               SETTLE_CYC + PLL_TICKS * TICK_PER + 1);
    measure(0, 1'b0, n);
    check("R6 stpclk hold after slp", n, SLP_EXIT_HOLD);
    measure(3, 1'b1, n);
    check("R7 freeze hold after stpclk", n, STP_EXIT_HOLD);
    check("R7 slpN high at freeze drop", slpN, 1);
    check("R7 stpClkN high at freeze drop", stpClkN, 1);
  endtask

  task automatic testWakeInSleep();
    int n;
    pulseSleep();
    pulseGrant();
    measure(1, 1'b1, n);
    check("R8 grant to slp", n, GRANT_TO_SLP);
    clkDropped = 1'b0;
    repeat (2) @(negedge clk);
    pulseWake();
    measure(1, 1'b0, n);
    check("R8 slp low length", n, SLP_TO_STOP - 3);
    measure(0, 1'b0, n);
    check("R8 stpclk hold", n, SLP_EXIT_HOLD);
    measure(3, 1'b1, n);
    check("R8 freeze hold", n, STP_EXIT_HOLD);
    check("R8 clock never gated", clkDropped, 0);
  endtask

  task automatic testWakeInStopGrant();
    int n;
    slpDropped = 1'b0;
    pulseSleep();
    pulseWake();
    repeat (2) @(negedge clk);
    check("R9 still stopped before grant", stpClkN, 0);
    pulseGrant();
    check("R9 freeze up", inputFreeze, 1);
    check("R9 stpclk low at freeze", stpClkN, 0);
    @(negedge clk);
    check("R9 stpclk released", stpClkN, 1);
    measure(3, 1'b1, n);
    check("R9 freeze hold", n, STP_EXIT_HOLD);
    check("R9 slp never asserted", slpDropped, 0);
  endtask

  task automatic testIgnored();
    int n;
    pulseWake();
    pulseGrant();
    check("R10 freeze in run", inputFreeze, 0);
    check("R10 stpclk in run", stpClkN, 1);
    check("R10 slp in run", slpN, 1);
    pulseSleep();
    pulseGrant();
    measure(1, 1'b1, n);
    check("R10 no stale wake", n, GRANT_TO_SLP);
    pulseSleep();
    measure(2, 1'b1, n);
    check("R11 sleepReq in sleep", n, SLP_TO_STOP - 1);
    pulseWake();
    measure(1, 1'b0, n);
    pulseWake();
    measure(0, 1'b0, n);
    check("R10 wake in exit ignored", n, SLP_EXIT_HOLD - 1);
    measure(3, 1'b1, n);
    check("R10 freeze hold", n, STP_EXIT_HOLD);
    repeat (5) @(negedge clk);
    check("R11 no new entry", stpClkN, 1);
    pulseSleep();
    pulseGrant();
    measure(1, 1'b1, n);
    check("R10 exit wake not kept", n, GRANT_TO_SLP);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    doReset();
    testDeepCycle();
    repeat (3) @(negedge clk);
    testWakeInSleep();
    repeat (3) @(negedge clk);
    testWakeInStopGrant();
    repeat (3) @(negedge clk);
    testIgnored();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule